// File: doc/BRIEF.md
# BCD Countdown Watchdog Timer

This block is a supervisory timer that counts down a four-digit BCD timeout, from 99.99 s at most to zero. The two low digits hold hundredths of a second and the two high digits hold whole seconds. Each pulse on a 100 Hz tick input removes one hundredth while the timer is enabled and the count is not zero.

When the count reaches zero, the block sets a sticky expiry flag. A steering bit then selects what it drives. With the bit set, it sends a reset pulse of fixed length. With the bit clear, it raises an interrupt level that stays up until software reads the status register.

Software services the timer by writing either count register. That write reloads the whole countdown from the programmed seconds and hundredths. Clearing the enable bit and writing zero to both count registers parks the timer.

Access goes through a byte-wide register bus. Writes take effect at the clock edge. Read data is combinational from the address.

Top module: `bcd_watchdog`

## Requirements
- R1: Register map on the 4-bit address. 0xC holds the hundredths byte (two BCD digits) and 0xD holds the seconds byte (two BCD digits); reads of these two return the live count. 0xE is status, with the expiry flag in bit 1. 0xF is control, with enable in bit 1 and steering in bit 0. Unused bits read 0, and every other address reads 0x00.
- R2: After a synchronous active-low reset, the following are all zero: the count, the programmed values, enable, steering, the flag, `wd_reset` and `wd_irq`.
- R3: On each clock where `tick` is high, enable is 1, the count is non-zero and no count register is written, the count drops by one hundredth. The drop uses a BCD borrow across all four digits, so 10.00 becomes 09.99.
- R4: With enable 0, ticks leave the count unchanged.
- R5: Writing 0xC or 0xD stores that byte as the new programmed value. It also reloads the full count from the programmed seconds and hundredths, using the new byte, on the same edge. This write is the service (kick) action.
- R6: A count of zero never decrements and never expires, even with enable 1 and ticks present.
- R7: When a tick takes the count from 00.01 to 00.00 with steering 1, the flag sets. `wd_reset` then goes high on the following cycle and stays high for exactly RST_CYCLES clocks (default 4).
- R8: When the same expiry happens with steering 0, the flag sets and `wd_irq` goes high on the next cycle. `wd_irq` stays high until the status register is read.
- R9: A read strobe at 0xE clears the flag and `wd_irq` from the next cycle, unless an expiry happens on that same edge, in which case the expiry wins.
- R10: A written BCD nibble above 9 is stored as 9, so 0xFF programs 99. Every count digit always stays in the range 0 to 9.
- R11: A count-register write on the same edge as a qualifying tick reloads the count and drops that tick. A control write on the same edge as a tick does not change how that tick is handled: the old enable and steering apply.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | One-clock pulse at 100 Hz |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (side effect on status only) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` |
| wd_reset | output | 1 | Reset pulse on expiry when steering is 1 |
| wd_irq | output | 1 | Interrupt level on expiry when steering is 0 |

## Verification
The assertions assume the following about the inputs:
- `tick` is a single-clock pulse, synchronous to `clk`.
- A new expiry is never produced while a reset pulse is still running. A retrigger would stretch the pulse, and the pulse-width property would not hold.

The directed stimulus spaces the reset-steered expiries by more than RST_CYCLES clocks. The pseudo-random phase writes the control register with steering held at 0, and seconds values of only 0 or 1. This keeps countdowns short and frequent, so many expiries happen without overlapping reset pulses.

// File: rtl/wdt_pkg.sv
// Shared constants and helpers for the BCD watchdog.
// Assumes a four-digit count split into two bytes on a 4-bit address bus.
package wdt_pkg;
    localparam int DIGITS  = 4;
    localparam int CNT_W   = DIGITS * 4;
    localparam int ADDR_W  = 4;
    localparam int DATA_W  = 8;

    localparam logic [ADDR_W-1:0] ADR_HUND = 4'hC;
    localparam logic [ADDR_W-1:0] ADR_SECS = 4'hD;
    localparam logic [ADDR_W-1:0] ADR_STAT = 4'hE;
    localparam logic [ADDR_W-1:0] ADR_CTRL = 4'hF;

    localparam int STAT_FLAG_BIT  = 1;
    localparam int CTRL_EN_BIT    = 1;
    localparam int CTRL_STEER_BIT = 0;

    // Clamp every nibble of a byte to a legal BCD digit.
    function automatic logic [DATA_W-1:0] bcd_sat(input logic [DATA_W-1:0] b);
        logic [DATA_W-1:0] r;
        for (int i = 0; i < DATA_W / 4; i++) begin
            r[i*4 +: 4] = (b[i*4 +: 4] > 4'd9) ? 4'd9 : b[i*4 +: 4];
        end
        return r;
    endfunction
endpackage

// File: rtl/wdt_bcd_digit.sv
// One BCD digit of the down-counter.
// Loads a value or steps down by one when a borrow arrives; wraps 0 to 9 and
// passes the borrow on. Assumes the load value is already a legal digit.
module wdt_bcd_digit (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load,
    input  logic [3:0] load_val,
    input  logic       borrow_in,
    output logic [3:0] digit,
    output logic       borrow_out
);
    // Borrow ripples on only when this digit wraps.
    assign borrow_out = borrow_in && (digit == 4'd0);

    // Digit register: reset, load, or decrement with wrap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit <= 4'd0;
        end else if (load) begin
            digit <= load_val;
        end else if (borrow_in) begin
            digit <= (digit == 4'd0) ? 4'd9 : digit - 4'd1;
        end
    end
endmodule

// File: rtl/wdt_bcd_count.sv
// Multi-digit BCD down-counter built as a chain of digit cells.
// The caller must only assert dec when the count is non-zero.
module wdt_bcd_count #(
    parameter int NDIG = wdt_pkg::DIGITS,
    localparam int W   = NDIG * 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic [W-1:0] count,
    output logic         is_zero,
    output logic         is_one
);
    logic [NDIG:0] borrow;

    // The lowest digit takes the decrement request as its borrow.
    assign borrow[0] = dec;

    for (genvar g = 0; g < NDIG; g++) begin : g_dig
        wdt_bcd_digit u_dig (
            .clk        (clk),
            .rst_n      (rst_n),
            .load       (load),
            .load_val   (load_val[g*4 +: 4]),
            .borrow_in  (borrow[g]),
            .digit      (count[g*4 +: 4]),
            .borrow_out (borrow[g+1])
        );
    end

    // Terminal-value decodes used for idling and expiry.
    assign is_zero = (count == '0);
    assign is_one  = (count == W'(1));
endmodule

// File: rtl/wdt_pulse.sv
// Fixed-width pulse stretcher.
// A fire request (re)starts a high output lasting WIDTH clocks.
module wdt_pulse #(
    parameter int WIDTH = 4,
    localparam int CW   = $clog2(WIDTH + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic pulse
);
    logic [CW-1:0] left_q;

    // Remaining-cycles counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q <= '0;
        end else if (fire) begin
            left_q <= CW'(WIDTH);
        end else if (left_q != '0) begin
            left_q <= left_q - CW'(1);
        end
    end

    // The output is high while cycles remain.
    assign pulse = (left_q != '0);
endmodule

// File: rtl/wdt_regs.sv
// Register file of the watchdog: programmed count, control, sticky flag and
// interrupt level, plus read mux. Assumes one access per clock.
module wdt_regs
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [CNT_W-1:0]  count,
    input  logic              expire,
    output logic [DATA_W-1:0] rdata,
    output logic              load,
    output logic [CNT_W-1:0]  load_val,
    output logic              en,
    output logic              steer,
    output logic              flag,
    output logic              irq
);
    logic [DATA_W-1:0] hund_q, secs_q, wsat;
    logic              wr_hund, wr_secs, wr_ctrl, rd_stat;

    // Access decode.
    assign wr_hund = wr_en && (addr == ADR_HUND);
    assign wr_secs = wr_en && (addr == ADR_SECS);
    assign wr_ctrl = wr_en && (addr == ADR_CTRL);
    assign rd_stat = rd_en && (addr == ADR_STAT);
    assign wsat    = bcd_sat(wdata);

    // Reload request and value, using the byte being written.
    assign load     = wr_hund || wr_secs;
    assign load_val = wr_hund ? {secs_q, wsat} : {wsat, hund_q};

    // Programmed count bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hund_q <= '0;
            secs_q <= '0;
        end else begin
            if (wr_hund) hund_q <= wsat;
            if (wr_secs) secs_q <= wsat;
        end
    end

    // Control bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en    <= 1'b0;
            steer <= 1'b0;
        end else if (wr_ctrl) begin
            en    <= wdata[CTRL_EN_BIT];
            steer <= wdata[CTRL_STEER_BIT];
        end
    end

    // Sticky flag and interrupt level; a new expiry beats a status read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
            irq  <= 1'b0;
        end else begin
            if (expire)       flag <= 1'b1;
            else if (rd_stat) flag <= 1'b0;
            if (expire && !steer) irq <= 1'b1;
            else if (rd_stat)     irq <= 1'b0;
        end
    end

    // Read mux.
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_HUND: rdata = count[7:0];
            ADR_SECS: rdata = count[15:8];
            ADR_STAT: rdata[STAT_FLAG_BIT] = flag;
            ADR_CTRL: begin
                rdata[CTRL_EN_BIT]    = en;
                rdata[CTRL_STEER_BIT] = steer;
            end
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/bcd_watchdog.sv
// Top of the BCD countdown watchdog.
// Ties the register file, BCD down-counter and reset-pulse stretcher together.
// Assumes tick is a one-clock pulse synchronous to clk.
module bcd_watchdog
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              wd_reset,
    output logic              wd_irq
);
    logic [CNT_W-1:0] count_q, load_val;
    logic             load, dec, expire, is_zero, is_one;
    logic             ctrl_en, ctrl_steer, flag;

    // Decrement qualification and expiry detection.
    assign dec    = tick && ctrl_en && !is_zero && !load;
    assign expire = dec && is_one;

    wdt_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .addr     (addr),
        .wdata    (wdata),
        .count    (count_q),
        .expire   (expire),
        .rdata    (rdata),
        .load     (load),
        .load_val (load_val),
        .en       (ctrl_en),
        .steer    (ctrl_steer),
        .flag     (flag),
        .irq      (wd_irq)
    );

    wdt_bcd_count #(.NDIG(DIGITS)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (load_val),
        .dec      (dec),
        .count    (count_q),
        .is_zero  (is_zero),
        .is_one   (is_one)
    );

    wdt_pulse #(.WIDTH(RST_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .fire  (expire && ctrl_steer),
        .pulse (wd_reset)
    );
endmodule

// File: rtl/wdt_checker.sv
// Property checker for bcd_watchdog, attached by bind.
// Assumes a reset pulse is never retriggered while it is still high.
module wdt_checker
    import wdt_pkg::*;
#(
    parameter int RST_CYCLES = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tick,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              wd_reset,
    input logic              wd_irq,
    input logic [CNT_W-1:0]  count,
    input logic              en,
    input logic              steer
);
    logic armed;
    int   run;
    logic cnt_wr, hits;

    // Marks cycles with at least one clean sample since reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // Length of the current reset pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)        run <= 0;
        else if (wd_reset) run <= run + 1;
        else               run <= 0;
    end

    assign cnt_wr = wr_en && (addr == ADR_HUND || addr == ADR_SECS);
    assign hits   = tick && en && (count == CNT_W'(1)) && !cnt_wr;

    function automatic int bcd_val(input logic [CNT_W-1:0] c);
        int v = 0;
        for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + int'(c[i*4 +: 4]);
        return v;
    endfunction

    function automatic logic digits_ok(input logic [CNT_W-1:0] c);
        logic ok = 1'b1;
        for (int i = 0; i < DIGITS; i++) if (c[i*4 +: 4] > 4'd9) ok = 1'b0;
        return ok;
    endfunction

    p_digit_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> digits_ok(count));

    p_tick_decrements_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && tick && en && count != '0 && !cnt_wr)
        |=> bcd_val(count) == bcd_val($past(count)) - 1);

    p_hold_when_disabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && !en && !cnt_wr) |=> $stable(count));

    p_write_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wr_en && addr == ADR_HUND) |=> count[7:0] == bcd_sat($past(wdata)));

    p_zero_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && count == '0 && !cnt_wr) |=> count == '0);

    p_reset_on_expiry_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hits && steer) |=> wd_reset);

    p_reset_width_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && $fell(wd_reset)) |-> run == RST_CYCLES);

    p_irq_on_expiry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && hits && !steer) |=> wd_irq);

    p_irq_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && wd_irq && !(rd_en && addr == ADR_STAT)) |=> wd_irq);

    p_stat_read_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && rd_en && addr == ADR_STAT && !hits) |=> !wd_irq);
endmodule

bind bcd_watchdog wdt_checker #(.RST_CYCLES(RST_CYCLES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wdata    (wdata),
    .wd_reset (wd_reset),
    .wd_irq   (wd_irq),
    .count    (count_q),
    .en       (ctrl_en),
    .steer    (ctrl_steer)
);

// File: tb/test_bcd_watchdog.sv
module test_bcd_watchdog;
    localparam int CLK_PERIOD = 10;
    localparam int PULSE      = 4;
    localparam int LIMIT      = 150000;

    logic       clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
    logic [3:0] addr = 4'h0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       wd_reset, wd_irq;

    int checks = 0, failures = 0, cycles = 0;
    string req = "R2";

    // Reference model state (binary integers).
    int m_hld = 0, m_sld = 0, m_cnt = 0, m_en = 0, m_steer = 0;
    int m_flag = 0, m_irq = 0, m_left = 0;

    bcd_watchdog #(.RST_CYCLES(PULSE)) i_bcd_watchdog (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .rd_en(rd_en),
        .addr(addr), .wdata(wdata), .rdata(rdata), .wd_reset(wd_reset), .wd_irq(wd_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic int sat_val(input logic [7:0] b);
        int hi = (b[7:4] > 4'd9) ? 9 : int'(b[7:4]);
        int lo = (b[3:0] > 4'd9) ? 9 : int'(b[3:0]);
        return hi * 10 + lo;
    endfunction

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [3:0] a);
        case (a)
            4'hC:    return to_bcd(m_cnt % 100);
            4'hD:    return to_bcd(m_cnt / 100);
            4'hE:    return {6'b0, 1'(m_flag), 1'b0};
            4'hF:    return {6'b0, 1'(m_en), 1'(m_steer)};
            default: return 8'h00;
        endcase
    endfunction

    // Advance the model by one clock edge using the held inputs.
    task automatic model_edge();
        int old_en = m_en, old_steer = m_steer;
        if (!rst_n) begin
            m_hld = 0; m_sld = 0; m_cnt = 0; m_en = 0; m_steer = 0;
            m_flag = 0; m_irq = 0; m_left = 0;
            return;
        end
        if (m_left > 0) m_left--;
        if (rd_en && addr == 4'hE) begin m_flag = 0; m_irq = 0; end
        if (wr_en && addr == 4'hC) begin
            m_hld = sat_val(wdata); m_cnt = m_sld * 100 + m_hld;
        end else if (wr_en && addr == 4'hD) begin
            m_sld = sat_val(wdata); m_cnt = m_sld * 100 + m_hld;
        end else if (tick && old_en != 0 && m_cnt > 0) begin
            m_cnt--;
            if (m_cnt == 0) begin
                m_flag = 1;
                if (old_steer != 0) m_left = PULSE; else m_irq = 1;
            end
        end
        if (wr_en && addr == 4'hF) begin m_en = int'(wdata[1]); m_steer = int'(wdata[0]); end
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h at cycle %0d", req, what, act, exp, cycles);
        end
    endtask

    // One clock with given inputs; compare all outputs after the edge.
    task automatic cyc(input logic w, input logic r, input logic [3:0] a,
                       input logic [7:0] d, input logic t);
        wr_en = w; rd_en = r; addr = a; wdata = d; tick = t;
        @(posedge clk);
        model_edge();
        @(negedge clk);
        chk({7'b0, wd_reset}, {7'b0, 1'(m_left > 0)}, "wd_reset");
        chk({7'b0, wd_irq}, {7'b0, 1'(m_irq)}, "wd_irq");
        chk(rdata, exp_rdata(a), "rdata");
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        cyc(1'b1, 1'b0, a, d, 1'b0);
    endtask

    task automatic run(input int n, input logic t, input logic [3:0] a);
        for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, a, 8'h00, t);
    endtask

    // Watchdog for a hung run.
    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT) begin
            failures++;
            $display("FAIL watchdog expired after %0d cycles", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        int lfsr = 16'hACE1;
        // R2: reset state
        req = "R2";
        run(3, 1'b0, 4'hC);
        rst_n = 1'b1;
        // R1: every address reads per the map, unused ones 0
        req = "R1";
        for (int a = 0; a < 16; a++) cyc(1'b0, 1'b1, 4'(a), 8'h00, 1'b0);

        // R8: interrupt steering, 00.05 countdown
        req = "R8";
        wr(4'hD, 8'h00); wr(4'hC, 8'h05); wr(4'hF, 8'h02);
        run(8, 1'b1, 4'hC);
        run(4, 1'b0, 4'hE);
        // R9: status read clears flag and interrupt
        req = "R9";
        cyc(1'b0, 1'b1, 4'hE, 8'h00, 1'b0);
        run(2, 1'b0, 4'hE);

        // R3: borrow 10.00 -> 09.99
        req = "R3";
        wr(4'hF, 8'h03); wr(4'hC, 8'h00); wr(4'hD, 8'h10);
        cyc(1'b0, 1'b0, 4'hD, 8'h00, 1'b1);
        cyc(1'b0, 1'b0, 4'hC, 8'h00, 1'b0);
        run(12, 1'b1, 4'hC);
        // R4: disabled ticks hold the count
        req = "R4";
        wr(4'hF, 8'h01);
        run(10, 1'b1, 4'hC);
        // R5: kick reloads full count from programmed bytes
        req = "R5";
        wr(4'hC, 8'h02);
        cyc(1'b0, 1'b0, 4'hD, 8'h00, 1'b0);

        // R7: reset steering, 00.02 countdown
        req = "R7";
        wr(4'hD, 8'h00); wr(4'hF, 8'h03);
        run(10, 1'b1, 4'hE);
        cyc(1'b0, 1'b1, 4'hE, 8'h00, 1'b0);

        // R6: zero count stays idle while enabled
        req = "R6";
        wr(4'hC, 8'h00);
        run(10, 1'b1, 4'hE);

        // R10: nibble saturation
        req = "R10";
        wr(4'hC, 8'hAF); cyc(1'b0, 1'b0, 4'hC, 8'h00, 1'b0);
        wr(4'hD, 8'hFB); cyc(1'b0, 1'b0, 4'hD, 8'h00, 1'b0);

        // R11: count write with tick reloads; control write with tick uses old enable
        req = "R11";
        wr(4'hF, 8'h02);
        run(3, 1'b1, 4'hC);
        cyc(1'b1, 1'b0, 4'hC, 8'h50, 1'b1);
        cyc(1'b1, 1'b0, 4'hF, 8'h00, 1'b1);
        cyc(1'b1, 1'b0, 4'hF, 8'h02, 1'b1);
        run(2, 1'b1, 4'hC);

        // R10: full 99.99 countdown to an interrupt
        req = "R10";
        wr(4'hD, 8'h99); wr(4'hC, 8'h99);
        run(10002, 1'b1, 4'hC);
        cyc(1'b0, 1'b1, 4'hE, 8'h00, 1'b0);

        // R3: pseudo-random mix, steering held at 0
        req = "R3";
        wr(4'hF, 8'h02);
        for (int i = 0; i < 3000; i++) begin
            logic [15:0] r;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 16'hB400 : 16'h0);
            r = 16'(lfsr);
            case (r[4:2])
                3'd0:    cyc(1'b1, 1'b0, 4'hC, r[15:8], r[0]);
                3'd1:    cyc(1'b1, 1'b0, 4'hD, {7'b0, r[8]}, r[0]);
                3'd2:    cyc(1'b1, 1'b0, 4'hF, {6'b0, r[5], 1'b0}, r[0]);
                3'd3:    cyc(1'b0, 1'b1, 4'hE, 8'h00, r[0]);
                default: cyc(1'b0, r[6], r[11:8], 8'h00, r[0]);
            endcase
        end

        // R2: reset mid-run returns everything to zero
        req = "R2";
        wr(4'hC, 8'h40);
        rst_n = 1'b0;
        run(2, 1'b1, 4'hC);
        rst_n = 1'b1;
        cyc(1'b0, 1'b0, 4'hF, 8'h00, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule